// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block collects completion and fault events from a set of DMA channels and turns them into four interrupt lines. Each channel keeps a separate cause register and a separate enable mask for every one of the four lines. This lets up to four software agents each own one line, with masks that do not affect one another. The transfer engines are outside the block. Each one reports through two single-cycle pulses: one when a descriptor finishes and one when an error occurs.

A channel's direction follows from its number. Even channels move data from memory to a device (transmit). Odd channels move data from a device to memory (receive). Channels are grouped into pairs: channel `c` belongs to pair `c/2`. Arming and disarming are done by pair bit, through separate transmit and receive start/stop registers. For each interrupt line the block builds two summary words, one for transmit and one for receive. Bit `p` of a summary word is high when the channel of that direction in pair `p` has an unmasked cause pending. A line is raised one clock after either of its summary words becomes non-zero.

Register access is a plain single-cycle write strobe plus a combinational read port. The block has no data stream, so there is no valid/ready handshake and no back-pressure. A write takes effect at the clock edge where `wr_en` is high. `rd_data` follows `rd_addr` in the same cycle.

Top module: `dmairq_top`

## Requirements
- R1: After reset, every cause register, mask register, channel enable, summary word and interrupt line reads as zero.
- R2: Enable registers work per pair bit `p`:
  - Writing a 1 in bit `p` to address 0x000 arms channel 2p. Writing a 1 in bit `p` to 0x001 disarms it.
  - Addresses 0x002 and 0x003 do the same for channel 2p+1.
  - Bits written as 0 leave the enable unchanged.
  - Reading 0x000 returns the transmit enables by pair bit. Reading 0x002 returns the receive enables by pair bit.
- R3: A done pulse on an armed channel sets bit 0 of that channel's cause register for all four lines at the next edge. An error pulse sets bit 6 in the same way. This happens whatever the masks hold.
- R4: Done and error pulses on a channel that is not armed leave its cause registers unchanged.
- R5: Writing a channel's cause register clears each of bits 0 and 6 that is written as 1, and leaves a bit written as 0 unchanged. If an event arrives in the same cycle as a clear of that bit, the bit ends up set.
- R6: Mask bit 0 lets the done cause contribute to a line, and mask bit 6 lets the error cause contribute. Each line has its own masks. With all of a line's masks at zero, that line stays low.
- R7: For line `o`, the transmit summary is read at 0x004+o and the receive summary at 0x008+o. In the transmit summary, bit `p` is 1 exactly when channel 2p has a cause bit set whose mask bit is also set for line `o`. The receive summary does the same for channel 2p+1.
- R8: Interrupt line `o` is high in the cycle after the cycle in which either of its summary words is non-zero, and low otherwise.
- R9: Channel `c` and line `o` have their cause register at 0x100 + 8c + 2o and their mask register one address above it. These registers read back only bits 0 and 6; all other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_ev | input | NUM_CH | Descriptor-done pulse per channel |
| err_ev | input | NUM_CH | Error pulse per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 10 | Read word address |
| rd_data | output | 32 | Combinational read data |
| irq_o | output | 4 | Interrupt lines |

## Verification
The assertions check four things on every cycle:
- a cause bit can only rise if its channel was armed and saw the matching event;
- a cause bit can only fall after a write-one-to-clear to that exact bit;
- a stop write disarms its channel;
- each line follows its summary words with a one-cycle lag, and stays low while all of its masks are zero.

Other behaviour can only be shown by the bench's scenarios:
- the exact address map and read-back format;
- that one event fans out to all four lines;
- that masks on one line do not affect another;
- that set wins over clear in the same cycle.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int IRQ_OUTS = 4;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 32;
  localparam int DONE_BIT = 0;
  localparam int ERR_BIT  = 6;
  localparam int MAX_CH   = 64;

  localparam logic [ADDR_W-1:0] A_TX_START = 10'h000;
  localparam logic [ADDR_W-1:0] A_TX_STOP  = 10'h001;
  localparam logic [ADDR_W-1:0] A_RX_START = 10'h002;
  localparam logic [ADDR_W-1:0] A_RX_STOP  = 10'h003;
  localparam logic [ADDR_W-1:0] A_TX_SUM   = 10'h004;
  localparam logic [ADDR_W-1:0] A_RX_SUM   = 10'h008;
  localparam logic [ADDR_W-1:0] CH_BASE    = 10'h100;

  typedef logic [1:0] cause_t;  // [1] error, [0] done

  function automatic logic [DATA_W-1:0] cause_word(cause_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[DONE_BIT] = c[0];
    w[ERR_BIT]  = c[1];
    return w;
  endfunction
endpackage

// File: rtl/dmairq_chan.sv
module dmairq_chan
  import dmairq_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        armed,
  input  logic                        done_ev,
  input  logic                        err_ev,
  input  logic [IRQ_OUTS-1:0]         wr_cause,
  input  logic [IRQ_OUTS-1:0]         wr_mask,
  input  cause_t                      wbits,
  output cause_t [IRQ_OUTS-1:0]       cause_q,
  output cause_t [IRQ_OUTS-1:0]       mask_q,
  output logic   [IRQ_OUTS-1:0]       pend
);
  cause_t set_v;
  assign set_v = {err_ev & armed, done_ev & armed};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      for (int o = 0; o < IRQ_OUTS; o++) begin
        cause_q[o] <= (cause_q[o] & ~(wr_cause[o] ? wbits : 2'b00)) | set_v;
        if (wr_mask[o]) mask_q[o] <= wbits;
      end
    end
  end

  for (genvar o = 0; o < IRQ_OUTS; o++) begin : g_pend
    assign pend[o] = |(cause_q[o] & mask_q[o]);
  end
endmodule

// File: rtl/dmairq_summary.sv
module dmairq_summary
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SUM_W  = (NUM_CH + 1) / 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_CH-1:0][IRQ_OUTS-1:0]       pend,
  output logic [IRQ_OUTS-1:0][SUM_W-1:0]        tx_sum,
  output logic [IRQ_OUTS-1:0][SUM_W-1:0]        rx_sum,
  output logic [IRQ_OUTS-1:0]                   irq_o
);
  always_comb begin
    tx_sum = '0;
    rx_sum = '0;
    for (int c = 0; c < NUM_CH; c++)
      for (int o = 0; o < IRQ_OUTS; o++)
        if (c % 2 == 0) tx_sum[o][c/2] = pend[c][o];
        else            rx_sum[o][c/2] = pend[c][o];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= '0;
    else
      for (int o = 0; o < IRQ_OUTS; o++)
        irq_o[o] <= (|tx_sum[o]) | (|rx_sum[o]);
  end
endmodule

// File: rtl/dmairq_top.sv
module dmairq_top
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CH-1:0]    done_ev,
  input  logic [NUM_CH-1:0]    err_ev,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic [IRQ_OUTS-1:0]  irq_o
);
  localparam int SUM_W = (NUM_CH + 1) / 2;

  initial begin
    if (NUM_CH < 1 || NUM_CH > MAX_CH) $error("NUM_CH out of range");
  end

  logic [NUM_CH-1:0]                en_q;
  cause_t [NUM_CH-1:0][IRQ_OUTS-1:0] ch_cause, ch_mask;
  logic [NUM_CH-1:0][IRQ_OUTS-1:0]  pend;
  logic [IRQ_OUTS-1:0][SUM_W-1:0]   tx_sum, rx_sum;

  // channel-region decode, write side
  logic              w_in_ch;
  logic [ADDR_W-1:0] w_off;
  assign w_in_ch = wr_en && (wr_addr >= CH_BASE);
  assign w_off   = wr_addr - CH_BASE;

  cause_t wbits;
  assign wbits = {wr_data[ERR_BIT], wr_data[DONE_BIT]};

  // enables, by pair bit
  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else if (wr_en) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_data[c/2]) begin
          if (c % 2 == 0) begin
            if (wr_addr == A_TX_START) en_q[c] <= 1'b1;
            if (wr_addr == A_TX_STOP)  en_q[c] <= 1'b0;
          end else begin
            if (wr_addr == A_RX_START) en_q[c] <= 1'b1;
            if (wr_addr == A_RX_STOP)  en_q[c] <= 1'b0;
          end
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [IRQ_OUTS-1:0] wc, wm;
    for (genvar o = 0; o < IRQ_OUTS; o++) begin : g_sel
      assign wc[o] = w_in_ch && (w_off[8:3] == 6'(c)) && (w_off[2:1] == 2'(o)) && !w_off[0];
      assign wm[o] = w_in_ch && (w_off[8:3] == 6'(c)) && (w_off[2:1] == 2'(o)) &&  w_off[0];
    end
    dmairq_chan u_chan (
      .clk(clk), .rst_n(rst_n), .armed(en_q[c]),
      .done_ev(done_ev[c]), .err_ev(err_ev[c]),
      .wr_cause(wc), .wr_mask(wm), .wbits(wbits),
      .cause_q(ch_cause[c]), .mask_q(ch_mask[c]), .pend(pend[c])
    );
  end

  dmairq_summary #(.NUM_CH(NUM_CH), .SUM_W(SUM_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .pend(pend),
    .tx_sum(tx_sum), .rx_sum(rx_sum), .irq_o(irq_o)
  );

  // read port
  logic [ADDR_W-1:0] r_off;
  assign r_off = rd_addr - CH_BASE;

  always_comb begin
    rd_data = '0;
    if (rd_addr >= CH_BASE) begin
      for (int c = 0; c < NUM_CH; c++)
        for (int o = 0; o < IRQ_OUTS; o++)
          if (r_off[8:3] == 6'(c) && r_off[2:1] == 2'(o))
            rd_data = cause_word(r_off[0] ? ch_mask[c][o] : ch_cause[c][o]);
    end else if (rd_addr == A_TX_START || rd_addr == A_RX_START) begin
      for (int c = 0; c < NUM_CH; c++)
        if ((c % 2 == 0) == (rd_addr == A_TX_START)) rd_data[c/2] = en_q[c];
    end else begin
      for (int o = 0; o < IRQ_OUTS; o++) begin
        if (rd_addr == A_TX_SUM + ADDR_W'(o)) rd_data[SUM_W-1:0] = tx_sum[o];
        if (rd_addr == A_RX_SUM + ADDR_W'(o)) rd_data[SUM_W-1:0] = rx_sum[o];
      end
    end
  end
endmodule

// File: rtl/dmairq_chk.sv
module dmairq_chk
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SUM_W  = (NUM_CH + 1) / 2
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic [NUM_CH-1:0]                   done_ev,
  input logic [NUM_CH-1:0]                   err_ev,
  input logic                                wr_en,
  input logic [ADDR_W-1:0]                   wr_addr,
  input logic [DATA_W-1:0]                   wr_data,
  input logic [NUM_CH-1:0]                   en_q,
  input cause_t [NUM_CH-1:0][IRQ_OUTS-1:0]   ch_cause,
  input cause_t [NUM_CH-1:0][IRQ_OUTS-1:0]   ch_mask,
  input logic [IRQ_OUTS-1:0][SUM_W-1:0]      tx_sum,
  input logic [IRQ_OUTS-1:0][SUM_W-1:0]      rx_sum,
  input logic [IRQ_OUTS-1:0]                 irq_o
);
  logic [IRQ_OUTS-1:0] any_mask;
  always_comb begin
    any_mask = '0;
    for (int c = 0; c < NUM_CH; c++)
      for (int o = 0; o < IRQ_OUTS; o++)
        any_mask[o] = any_mask[o] | (|ch_mask[c][o]);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    localparam logic [ADDR_W-1:0] STOP_A = (c % 2 == 0) ? A_TX_STOP : A_RX_STOP;
    p_stop_disarms_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == STOP_A && wr_data[c/2]) |=> !en_q[c]);
    for (genvar o = 0; o < IRQ_OUTS; o++) begin : g_o
      localparam logic [ADDR_W-1:0] CA = CH_BASE + ADDR_W'(c*8 + o*2);
      p_done_needs_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch_cause[c][o][0]) |-> $past(en_q[c] && done_ev[c]));
      p_err_needs_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch_cause[c][o][1]) |-> $past(en_q[c] && err_ev[c]));
      p_done_clear_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ch_cause[c][o][0]) |-> $past(wr_en && wr_addr == CA && wr_data[DONE_BIT]));
      p_err_clear_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ch_cause[c][o][1]) |-> $past(wr_en && wr_addr == CA && wr_data[ERR_BIT]));
    end
  end

  for (genvar o = 0; o < IRQ_OUTS; o++) begin : g_line
    p_irq_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[o] == $past((|tx_sum[o]) || (|rx_sum[o])));
    p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(any_mask[o]) |-> !irq_o[o]);
  end
endmodule

bind dmairq_top dmairq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .done_ev(done_ev), .err_ev(err_ev),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .en_q(en_q),
  .ch_cause(ch_cause), .ch_mask(ch_mask), .tx_sum(tx_sum), .rx_sum(rx_sum),
  .irq_o(irq_o)
);

// File: tb/tb_dmairq_top.sv
module tb_dmairq_top;
  localparam int NCH = 8;
  localparam int NO  = 4;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] done_ev = '0, err_ev = '0;
  logic wr_en = 0;
  logic [9:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [NO-1:0] irq_o;

  dmairq_top #(.NUM_CH(NCH)) dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit m_en [NCH];
  bit [1:0] m_st [NCH][NO];
  bit [1:0] m_mk [NCH][NO];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stw(bit [1:0] b);
    return {25'd0, b[1], 5'd0, b[0]};
  endfunction

  function automatic logic [31:0] exp_sum(bit rx, int o);
    logic [31:0] w = '0;
    for (int c = 0; c < NCH; c++)
      if ((c % 2 == 1) == rx && (m_st[c][o] & m_mk[c][o]) != 0) w[c/2] = 1'b1;
    return w;
  endfunction

  function automatic logic [31:0] exp_en(bit rx);
    logic [31:0] w = '0;
    for (int c = 0; c < NCH; c++)
      if ((c % 2 == 1) == rx) w[c/2] = m_en[c];
    return w;
  endfunction

  function automatic logic [9:0] caddr(int c, int o, bit msk);
    return 10'(256 + c*8 + o*2 + int'(msk));
  endfunction

  // model next state, using enables from before the edge
  task automatic model(logic [NCH-1:0] d, logic [NCH-1:0] e, bit we, logic [9:0] a, logic [31:0] wd);
    bit old_en [NCH];
    old_en = m_en;
    if (we) begin
      for (int c = 0; c < NCH; c++) begin
        if (wd[c/2]) begin
          if (c % 2 == 0 && a == 10'h000) m_en[c] = 1;
          if (c % 2 == 0 && a == 10'h001) m_en[c] = 0;
          if (c % 2 == 1 && a == 10'h002) m_en[c] = 1;
          if (c % 2 == 1 && a == 10'h003) m_en[c] = 0;
        end
        for (int o = 0; o < NO; o++) begin
          if (a == caddr(c, o, 0)) m_st[c][o] &= ~{wd[6], wd[0]};
          if (a == caddr(c, o, 1)) m_mk[c][o] = {wd[6], wd[0]};
        end
      end
    end
    for (int c = 0; c < NCH; c++)
      for (int o = 0; o < NO; o++)
        m_st[c][o] |= {e[c] & old_en[c], d[c] & old_en[c]};
  endtask

  task automatic step(logic [NCH-1:0] d, logic [NCH-1:0] e, bit we, logic [9:0] a, logic [31:0] wd);
    done_ev = d; err_ev = e; wr_en = we; wr_addr = a; wr_data = wd;
    @(posedge clk); #1;
    done_ev = '0; err_ev = '0; wr_en = 0;
    model(d, e, we, a, wd);
    @(negedge clk);
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d); step('0, '0, 1, a, d); endtask
  task automatic idle(); step('0, '0, 0, '0, '0); endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic full_check(int c);
    logic [31:0] v;
    for (int o = 0; o < NO; o++) begin
      rd(caddr(c, o, 0), v); check("R3/R5/R9 cause", v, stw(m_st[c][o]));
      rd(caddr(c, o, 1), v); check("R6/R9 mask", v, stw(m_mk[c][o]));
      rd(10'(4 + o), v); check("R7 tx summary", v, exp_sum(0, o));
      rd(10'(8 + o), v); check("R7 rx summary", v, exp_sum(1, o));
      check("R8 irq", 32'(irq_o[o]), 32'((exp_sum(0, o) | exp_sum(1, o)) != 0));
    end
    rd(10'h000, v); check("R2 tx enables", v, exp_en(0));
    rd(10'h002, v); check("R2 rx enables", v, exp_en(1));
  endtask

  bit done_flag = 0;
  initial begin
    #(20 * 150000);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    for (int c = 0; c < NCH; c++) begin
      m_en[c] = 0;
      for (int o = 0; o < NO; o++) begin m_st[c][o] = 0; m_mk[c][o] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 irq", 32'(irq_o), 0);
    for (int c = 0; c < NCH; c++) full_check(c);

    // R4 event on stopped channel 0
    step(8'h01, 8'h01, 0, '0, '0); idle();
    rd(caddr(0, 2, 0), v); check("R4 stopped ignored", v, 0);

    // R2 arm ch0 (tx pair0) and ch3 (rx pair1)
    wr(10'h000, 32'h1); wr(10'h002, 32'h2);
    rd(10'h000, v); check("R2 tx start", v, 32'h1);
    rd(10'h002, v); check("R2 rx start", v, 32'h2);

    // R3 done on ch0 with masks zero: all lines latch, irq low (R6)
    step(8'h01, '0, 0, '0, '0);
    for (int o = 0; o < NO; o++) begin rd(caddr(0, o, 0), v); check("R3 done latched", v, 32'h1); end
    idle(); check("R6 masked no irq", 32'(irq_o), 0);

    // R8 timing: mask line1 done for ch0
    wr(caddr(0, 1, 1), 32'h1);
    rd(10'h005, v); check("R7 tx sum line1", v, 32'h1);
    check("R8 irq not yet", 32'(irq_o[1]), 0);
    idle(); check("R8 irq line1 set", 32'(irq_o), 32'h2);

    // R7 error on ch3, line2 mask error
    step('0, 8'h08, 0, '0, '0);
    wr(caddr(3, 2, 1), 32'h40); idle();
    rd(10'h00A, v); check("R7 rx sum line2", v, 32'h2);
    check("R6 per-line irq", 32'(irq_o), 32'h6);

    // R5 W1C
    wr(caddr(0, 1, 0), 32'h40);
    rd(caddr(0, 1, 0), v); check("R5 zero bit kept", v, 32'h1);
    wr(caddr(0, 1, 0), 32'hFFFF_FFBF);
    rd(caddr(0, 1, 0), v); check("R5 cleared", v, 32'h0);
    rd(caddr(0, 0, 0), v); check("R5 other line kept", v, 32'h1);
    step(8'h01, '0, 1, caddr(0, 1, 0), 32'h1);
    rd(caddr(0, 1, 0), v); check("R5 set wins", v, 32'h1);

    // R2 stop ch0 then event ignored
    wr(10'h001, 32'h1); wr(caddr(0, 3, 0), 32'h41);
    step(8'h01, 8'h01, 0, '0, '0);
    rd(caddr(0, 3, 0), v); check("R4 after stop", v, 0);
    idle(); full_check(0); full_check(3);

    // constrained random
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom % 5);
      int c = int'($urandom % NCH);
      int o = int'($urandom % NO);
      case (op)
        0: step(8'($urandom), 8'($urandom) & 8'($urandom), 0, '0, '0);
        1: wr(10'($urandom % 4), $urandom & 32'hF);
        2: wr(caddr(c, o, 0), $urandom);
        3: wr(caddr(c, o, 1), $urandom);
        default: step(8'($urandom), 8'($urandom), 1, caddr(c, o, 0), $urandom);
      endcase
      idle();
      full_check(int'($urandom % NCH));
    end

    done_flag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule